// File: doc/BRIEF.md
# Conditional branch resolver

This block resolves short relative branches for an 8-bit processor core. For each branch instruction it receives the opcode, the address of the instruction, an 8-bit two's-complement displacement and the four condition flags (negative, zero, overflow, carry). It decides whether the branch is taken and computes the address to continue from. It also reports how many program-fetch cycles the instruction costs, so that the sequencer can schedule the queue refill.

A request is offered with a one-cycle strobe. On the next clock the block presents the decision, the next address, the cycle cost and an invalid indication together, marked by a one-cycle result strobe. Between requests the result registers keep their last value. Opcodes outside the six supported conditions are reported as invalid and fall through to the next sequential instruction.

Top module: `brcond_resolver`

## Requirements
- R1: After synchronous reset, res_valid, res_taken and res_invalid are 0, res_next_pc is 0x0000 and res_cycles is 0.
- R2: Opcode 0x24 is taken exactly when the carry flag is 0.
- R3: Opcode 0x25 is taken exactly when the carry flag is 1.
- R4: Opcode 0x27 is taken exactly when the zero flag is 1.
- R5: Opcode 0x2C is taken exactly when negative XOR overflow is 0.
- R6: Opcode 0x2E is taken exactly when zero OR (negative XOR overflow) is 0.
- R7: Opcode 0x22 is taken exactly when carry OR zero is 0.
- R8: For a taken branch, res_next_pc is the request address plus 2 plus the sign-extended displacement, modulo 2^16.
- R9: For a branch that is not taken, res_next_pc is the request address plus 2, modulo 2^16.
- R10: res_cycles is 3 for a taken branch and 1 for a branch that is not taken.
- R11: Any other opcode sets res_invalid to 1, with res_taken 0, res_next_pc equal to the address plus 2 and res_cycles 1. A supported opcode sets res_invalid to 0.
- R12: Results appear on the clock edge after the one that samples req_valid high. res_valid is high for exactly that one cycle, and all result outputs hold their values while req_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per branch |
| req_opcode | input | 8 | Branch opcode |
| req_pc | input | 16 | Address of the branch instruction |
| req_offset | input | 8 | Signed relative displacement |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| res_valid | output | 1 | Result strobe |
| res_taken | output | 1 | Branch taken |
| res_next_pc | output | 16 | Address to continue from |
| res_cycles | output | 2 | Program-fetch cycles consumed |
| res_invalid | output | 1 | Opcode not a supported condition |

## Verification
The state in this block is a single register stage, so a wrong decode or flag equation shows up one clock after the strobe. It appears as a wrong taken bit, and because the cycle count and the next address both depend on that bit, all three outputs disagree at once. A fault in the sign extension or in the wrap of the adder shows up only in the next address, and only for negative displacements or for addresses near the top of the space. The tests therefore push those extremes. A stuck strobe register or a missing enable on the result registers shows up in the idle cycles after a result, as a lingering res_valid or a changed output.

// File: rtl/brcond_pkg.sv
package brcond_pkg;
  localparam int OPC_W = 8;

  localparam logic [OPC_W-1:0] OPC_CARRY_CLR = 8'h24;
  localparam logic [OPC_W-1:0] OPC_CARRY_SET = 8'h25;
  localparam logic [OPC_W-1:0] OPC_EQUAL     = 8'h27;
  localparam logic [OPC_W-1:0] OPC_SGE       = 8'h2C;
  localparam logic [OPC_W-1:0] OPC_SGT       = 8'h2E;
  localparam logic [OPC_W-1:0] OPC_UGT       = 8'h22;

  typedef enum logic [2:0] {
    COND_NONE,
    COND_CC,
    COND_CS,
    COND_EQ,
    COND_GE,
    COND_GT,
    COND_HI
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/brcond_decode.sv
module brcond_decode
  import brcond_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output cond_e            cond,
  output logic             known
);
  always_comb begin
    cond  = COND_NONE;
    known = 1'b1;
    unique case (opcode)
      OPC_CARRY_CLR: cond = COND_CC;
      OPC_CARRY_SET: cond = COND_CS;
      OPC_EQUAL:     cond = COND_EQ;
      OPC_SGE:       cond = COND_GE;
      OPC_SGT:       cond = COND_GT;
      OPC_UGT:       cond = COND_HI;
      default:       known = 1'b0;
    endcase
  end
endmodule

// File: rtl/brcond_eval.sv
module brcond_eval
  import brcond_pkg::*;
(
  input  cond_e  cond,
  input  flags_t flags,
  output logic   take
);
  logic sign_mismatch;

  always_comb begin
    sign_mismatch = flags.n ^ flags.v;
    case (cond)
      COND_CC: take = ~flags.c;
      COND_CS: take = flags.c;
      COND_EQ: take = flags.z;
      COND_GE: take = ~sign_mismatch;
      COND_GT: take = ~(flags.z | sign_mismatch);
      COND_HI: take = ~(flags.c | flags.z);
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/brcond_target.sv
module brcond_target #(
  parameter int PC_W     = 16,
  parameter int OFF_W    = 8,
  parameter int INSN_LEN = 2
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] offset,
  output logic [PC_W-1:0]  seq_pc,
  output logic [PC_W-1:0]  branch_pc
);
  logic [PC_W-1:0] ext_off;

  generate
    if (OFF_W < PC_W) begin : g_extend
      assign ext_off = {{(PC_W-OFF_W){offset[OFF_W-1]}}, offset};
    end else begin : g_trunc
      assign ext_off = offset[PC_W-1:0];
    end
  endgenerate

  assign seq_pc    = pc + PC_W'(INSN_LEN);
  assign branch_pc = seq_pc + ext_off;
endmodule

// File: rtl/brcond_resolver.sv
module brcond_resolver
  import brcond_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int OFF_W     = 8,
  parameter int CYC_W     = 2,
  parameter int INSN_LEN  = 2,
  parameter int TAKEN_CYC = 3,
  parameter int SEQ_CYC   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [7:0]       req_opcode,
  input  logic [PC_W-1:0]  req_pc,
  input  logic [OFF_W-1:0] req_offset,
  input  logic             flag_n,
  input  logic             flag_z,
  input  logic             flag_v,
  input  logic             flag_c,
  output logic             res_valid,
  output logic             res_taken,
  output logic [PC_W-1:0]  res_next_pc,
  output logic [CYC_W-1:0] res_cycles,
  output logic             res_invalid
);
  localparam logic [CYC_W-1:0] CYC_TAKEN = CYC_W'(TAKEN_CYC);
  localparam logic [CYC_W-1:0] CYC_SEQ   = CYC_W'(SEQ_CYC);

  cond_e           cond;
  logic            known;
  logic            take;
  flags_t          flags;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] branch_pc;

  assign flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

  brcond_decode u_decode (
    .opcode (req_opcode),
    .cond   (cond),
    .known  (known)
  );

  brcond_eval u_eval (
    .cond  (cond),
    .flags (flags),
    .take  (take)
  );

  brcond_target #(
    .PC_W     (PC_W),
    .OFF_W    (OFF_W),
    .INSN_LEN (INSN_LEN)
  ) u_target (
    .pc        (req_pc),
    .offset    (req_offset),
    .seq_pc    (seq_pc),
    .branch_pc (branch_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_taken   <= 1'b0;
      res_next_pc <= '0;
      res_cycles  <= '0;
      res_invalid <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_taken   <= take;
        res_next_pc <= take ? branch_pc : seq_pc;
        res_cycles  <= take ? CYC_TAKEN : CYC_SEQ;
        res_invalid <= ~known;
      end
    end
  end
endmodule

// File: rtl/brcond_resolver_chk.sv
module brcond_resolver_chk #(
  parameter int PC_W      = 16,
  parameter int OFF_W     = 8,
  parameter int CYC_W     = 2,
  parameter int INSN_LEN  = 2,
  parameter int TAKEN_CYC = 3,
  parameter int SEQ_CYC   = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [7:0]       req_opcode,
  input logic [PC_W-1:0]  req_pc,
  input logic             flag_c,
  input logic             flag_z,
  input logic             res_valid,
  input logic             res_taken,
  input logic [PC_W-1:0]  res_next_pc,
  input logic [CYC_W-1:0] res_cycles,
  input logic             res_invalid
);
  // R12: strobe follows request by one cycle
  a_r12_strobe_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);
  a_r12_strobe_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid);
  a_r12_hold_pc: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(res_next_pc) && $stable(res_taken));
  // R10: cycle cost matches decision
  a_r10_cycle_cost: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_cycles == (res_taken ? CYC_W'(TAKEN_CYC) : CYC_W'(SEQ_CYC)));
  // R11: invalid never branches
  a_r11_invalid_not_taken: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_invalid |-> !res_taken);
  // R9: fall-through address
  a_r9_seq_pc: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_taken || res_next_pc == $past(req_pc) + PC_W'(INSN_LEN));
  // R2: carry-clear condition
  a_r2_carry_clear: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_opcode == 8'h24 |=> res_taken == !$past(flag_c));
  // R7: unsigned higher condition
  a_r7_higher: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_opcode == 8'h22 |=> res_taken == !($past(flag_c) || $past(flag_z)));
endmodule

bind brcond_resolver brcond_resolver_chk #(
  .PC_W(PC_W), .OFF_W(OFF_W), .CYC_W(CYC_W),
  .INSN_LEN(INSN_LEN), .TAKEN_CYC(TAKEN_CYC), .SEQ_CYC(SEQ_CYC)
) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_opcode(req_opcode),
  .req_pc(req_pc), .flag_c(flag_c), .flag_z(flag_z),
  .res_valid(res_valid), .res_taken(res_taken), .res_next_pc(res_next_pc),
  .res_cycles(res_cycles), .res_invalid(res_invalid)
);

// File: tb/brcond_resolver_tb_top.sv
`timescale 1ns/1ps
module brcond_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [7:0]  req_opcode;
  logic [15:0] req_pc;
  logic [7:0]  req_offset;
  logic        flag_n, flag_z, flag_v, flag_c;
  logic        res_valid, res_taken, res_invalid;
  logic [15:0] res_next_pc;
  logic [1:0]  res_cycles;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  brcond_resolver dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_pc(req_pc), .req_offset(req_offset),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .res_valid(res_valid), .res_taken(res_taken), .res_next_pc(res_next_pc),
    .res_cycles(res_cycles), .res_invalid(res_invalid)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic bit model_take(logic [7:0] op, logic [3:0] nzvc);
    logic n, z, v, c;
    {n, z, v, c} = nzvc;
    case (op)
      8'h24:   return !c;
      8'h25:   return c;
      8'h27:   return z;
      8'h2C:   return (n == v);
      8'h2E:   return !z && (n == v);
      8'h22:   return !c && !z;
      default: return 1'b0;
    endcase
  endfunction

  // drive one request, sample result one edge later
  task automatic issue(string req, logic [7:0] op, logic [15:0] pc,
                       logic [7:0] off, logic [3:0] nzvc);
    bit          tk;
    bit          known;
    logic [15:0] exp_pc;
    tk     = model_take(op, nzvc);
    known  = (op == 8'h24 || op == 8'h25 || op == 8'h27 ||
              op == 8'h2C || op == 8'h2E || op == 8'h22);
    exp_pc = tk ? 16'(pc + 16'd2 + {{8{off[7]}}, off}) : 16'(pc + 16'd2);
    @(negedge clk);
    req_valid  = 1'b1;
    req_opcode = op;
    req_pc     = pc;
    req_offset = off;
    {flag_n, flag_z, flag_v, flag_c} = nzvc;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid R12"}, res_valid, 1);
    check({req, " taken"}, res_taken, tk);
    check({req, " next pc R8/R9"}, res_next_pc, exp_pc);
    check({req, " cycles R10"}, res_cycles, tk ? 2'd3 : 2'd1);
    check({req, " invalid R11"}, res_invalid, !known);
  endtask

  task automatic t_reset();
    rst = 1'b1; req_valid = 1'b0; req_opcode = '0; req_pc = '0; req_offset = '0;
    {flag_n, flag_z, flag_v, flag_c} = 4'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 res_valid", res_valid, 0);
    check("R1 res_taken", res_taken, 0);
    check("R1 res_next_pc", res_next_pc, 0);
    check("R1 res_cycles", res_cycles, 0);
    check("R1 res_invalid", res_invalid, 0);
  endtask

  task automatic t_carry();
    issue("R2 cc c0", 8'h24, 16'h1000, 8'h10, 4'b0000);
    issue("R2 cc c1", 8'h24, 16'h1000, 8'h10, 4'b0001);
    issue("R3 cs c1", 8'h25, 16'h2000, 8'hF0, 4'b1101);
    issue("R3 cs c0", 8'h25, 16'h2000, 8'hF0, 4'b1110);
  endtask

  task automatic t_equal();
    issue("R4 eq z1", 8'h27, 16'h3456, 8'h05, 4'b0100);
    issue("R4 eq z0", 8'h27, 16'h3456, 8'h05, 4'b1011);
  endtask

  task automatic t_signed();
    for (int f = 0; f < 16; f++) begin
      issue("R5 ge", 8'h2C, 16'h4000 + 16'(f), 8'h20, 4'(f));
      issue("R6 gt", 8'h2E, 16'h5000 + 16'(f), 8'hE0, 4'(f));
    end
  endtask

  task automatic t_unsigned();
    for (int f = 0; f < 16; f++)
      issue("R7 hi", 8'h22, 16'h6000, 8'h7F, 4'(f));
  endtask

  task automatic t_wrap();
    issue("R8 wrap up", 8'h24, 16'hFFF0, 8'h7F, 4'b0000);
    check("R8 wrap up value", res_next_pc, 16'h0071);
    issue("R8 wrap down", 8'h25, 16'h0001, 8'h80, 4'b0001);
    check("R8 wrap down value", res_next_pc, 16'hFF83);
    issue("R9 seq wrap", 8'h27, 16'hFFFF, 8'h40, 4'b0000);
    check("R9 seq wrap value", res_next_pc, 16'h0001);
  endtask

  task automatic t_invalid();
    issue("R11 op00", 8'h00, 16'h7000, 8'h10, 4'b0000);
    issue("R11 op26", 8'h26, 16'h7100, 8'h10, 4'b0000);
    issue("R11 op2D", 8'h2D, 16'h7200, 8'h80, 4'b1111);
    issue("R11 opFF", 8'hFF, 16'hFFFE, 8'h01, 4'b0000);
  endtask

  task automatic t_hold();
    issue("R12 setup", 8'h24, 16'h0800, 8'h30, 4'b0000);
    // idle with different inputs on the pins: nothing must move
    req_opcode = 8'h25; req_pc = 16'h1234; req_offset = 8'h55;
    {flag_n, flag_z, flag_v, flag_c} = 4'b0001;
    repeat (3) begin
      @(negedge clk);
      check("R12 idle valid", res_valid, 0);
      check("R12 idle pc", res_next_pc, 16'h0832);
      check("R12 idle taken", res_taken, 1);
      check("R12 idle cycles", res_cycles, 2'd3);
    end
  endtask

  initial begin
    t_reset();
    t_carry();
    t_equal();
    t_signed();
    t_unsigned();
    t_wrap();
    t_invalid();
    t_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule